// File: doc/BRIEF.md
# Dual-Engine Triangle Dispatcher and Output Merger

This block sits between a single 32-bit vertex word stream and a pair of triangle setup engines. It counts incoming words into whole vertices using a programmable vertex size. It groups the vertices into triangles and sends each triangle, word by word, to one engine. The next triangle goes to the other engine. The first triangle of a sequence can hold a different number of vertices from the triangles that follow. This covers separate triangles (three new vertices each) as well as strips and fans (three vertices first, then one new vertex per triangle).

On the output side, a serializer builds one ordered command stream for the rasterizer. It draws on three sources: the result bursts of engine 0, the result bursts of engine 1, and bursts of direct commands from the host. Engine bursts are granted in the same alternating order in which the triangles were dispatched, so triangle order is kept. Host bursts go in only between two bursts, never inside one.

Every path uses a valid/ready handshake with no storage at the edge. A stalled engine therefore holds back the input stream. Loading a new configuration restarts the vertex and triangle counting and returns both the dispatch side and the merge side to engine 0.

Top module: `tri_dispatch`

## Requirements
- R1: After reset no engine and no output valid is raised while no source is valid, `out_src` reads 0, and the first word offered is routed to engine 0.
- R2: `cfg_vsize` sets the number of words per vertex, with a value of 0 taken as 1. `engN_vend` is high on the last word of every vertex, and it is always high together with `engN_tend`.
- R3: The first triangle after reset or a load holds `cfg_first_nv` vertices and every later triangle holds `cfg_next_nv` vertices, with 0 taken as 1 in both fields. `engN_tend` is high on the last word of each triangle.
- R4: All words of one triangle go to a single engine, and the triangle after it goes to the other engine. At most one of `eng0_valid` and `eng1_valid` is high in any cycle.
- R5: `vin_ready` equals the ready of the engine that owns the current triangle. The input word appears unchanged on `engN_data`.
- R6: In a cycle with `cfg_load` high, the three fields are captured, `vin_ready` is low, and no engine valid is raised. From the next cycle, counting restarts with a first triangle, dispatch starts at engine 0, and the merger expects engine 0 next.
- R7: Engine result bursts are granted alternately, engine 0 first. The engine words on the output come out in the same order as the input words.
- R8: Once a burst has transferred a word without `last`, the output stays with that source until that source's `last` word has been transferred.
- R9: At a burst boundary a valid host word wins over the expected engine. The engine that is not expected is never granted, even when it is valid.
- R10: `out_src` encodes the selected source: 0 none, 1 host, 2 engine 0, 3 engine 1.
- R11: The output carries the selected source's valid, data and last in the same cycle. Only the selected source sees `out_ready`, and every other source's ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration and restart the sequence |
| cfg_vsize | input | 4 | Words per vertex |
| cfg_first_nv | input | 2 | Vertices in the first triangle of a sequence |
| cfg_next_nv | input | 2 | Vertices in each later triangle |
| vin_valid | input | 1 | Input word valid |
| vin_data | input | 32 | Input vertex word |
| vin_ready | output | 1 | Input word accepted |
| eng0_valid | output | 1 | Word valid toward engine 0 |
| eng0_data | output | 32 | Word toward engine 0 |
| eng0_vend | output | 1 | Last word of a vertex (engine 0) |
| eng0_tend | output | 1 | Last word of a triangle (engine 0) |
| eng0_ready | input | 1 | Engine 0 accepts a word |
| eng1_valid | output | 1 | Word valid toward engine 1 |
| eng1_data | output | 32 | Word toward engine 1 |
| eng1_vend | output | 1 | Last word of a vertex (engine 1) |
| eng1_tend | output | 1 | Last word of a triangle (engine 1) |
| eng1_ready | input | 1 | Engine 1 accepts a word |
| res0_valid | input | 1 | Engine 0 result word valid |
| res0_data | input | 32 | Engine 0 result word |
| res0_last | input | 1 | Last word of an engine 0 burst |
| res0_ready | output | 1 | Engine 0 result accepted |
| res1_valid | input | 1 | Engine 1 result word valid |
| res1_data | input | 32 | Engine 1 result word |
| res1_last | input | 1 | Last word of an engine 1 burst |
| res1_ready | output | 1 | Engine 1 result accepted |
| host_valid | input | 1 | Host command word valid |
| host_data | input | 32 | Host command word |
| host_last | input | 1 | Last word of a host burst |
| host_ready | output | 1 | Host word accepted |
| out_valid | output | 1 | Merged word valid |
| out_data | output | 32 | Merged word |
| out_last | output | 1 | Last word of the current burst |
| out_src | output | 2 | Selected source code |
| out_ready | input | 1 | Rasterizer accepts a word |

## Verification
Two situations can fall in the same cycle. The first is a host command and the expected engine's result both waiting at a burst boundary. The second is a burst ending while the other engine's result is already valid. The bench sets up the first case by holding `out_ready` low while both the host queue and the engine results fill, then releasing it. At that point the source code must name the host and then return to the engine that was expected. The bench also checks that words from the engines leave in the exact order they entered, even though the host words are mixed in between them.

// File: rtl/tri_dispatch_pkg.sv
package tri_dispatch_pkg;

    localparam int NUM_ENG = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOST = 2'd1,
        SRC_ENG0 = 2'd2,
        SRC_ENG1 = 2'd3
    } src_e;

    function automatic int unsigned nz(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/tri_cfg.sv
module tri_cfg
    import tri_dispatch_pkg::*;
#(
    parameter int VSW          = 4,
    parameter int NVW          = 2,
    parameter int DEF_VSIZE    = 8,
    parameter int DEF_FIRST_NV = 3,
    parameter int DEF_NEXT_NV  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [VSW-1:0]     vsize_in,
    input  logic [NVW-1:0]     first_nv_in,
    input  logic [NVW-1:0]     next_nv_in,
    output logic [VSW-1:0]     vsize_o,
    output logic [VSW+NVW-1:0] first_words_o,
    output logic [VSW+NVW-1:0] next_words_o
);
    localparam int CW = VSW + NVW;
    localparam int RST_VS = DEF_VSIZE;
    localparam int RST_FW = DEF_VSIZE * DEF_FIRST_NV;
    localparam int RST_NW = DEF_VSIZE * DEF_NEXT_NV;

    always_ff @(posedge clk) begin
        if (rst) begin
            vsize_o       <= VSW'(RST_VS);
            first_words_o <= CW'(RST_FW);
            next_words_o  <= CW'(RST_NW);
        end else if (load) begin
            vsize_o       <= VSW'(nz(int'(vsize_in)));
            first_words_o <= CW'(nz(int'(vsize_in)) * nz(int'(first_nv_in)));
            next_words_o  <= CW'(nz(int'(vsize_in)) * nz(int'(next_nv_in)));
        end
    end
endmodule

// File: rtl/vtx_splitter.sv
module vtx_splitter
    import tri_dispatch_pkg::*;
#(
    parameter int DW  = 32,
    parameter int VSW = 4,
    parameter int CW  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [VSW-1:0]     vsize,
    input  logic [CW-1:0]      first_words,
    input  logic [CW-1:0]      next_words,
    input  logic               in_valid,
    input  logic [DW-1:0]      in_data,
    output logic               in_ready,
    output logic [NUM_ENG-1:0] eng_valid,
    output logic [DW-1:0]      eng_data,
    output logic               eng_vend,
    output logic               eng_tend,
    input  logic [NUM_ENG-1:0] eng_ready
);
    localparam int EW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    logic [EW-1:0]  tgt;
    logic [CW-1:0]  wcnt;
    logic [VSW-1:0] vcnt;
    logic           first_tri;
    logic [CW-1:0]  tri_words;
    logic           fire;

    assign tri_words = first_tri ? first_words : next_words;
    assign eng_tend  = (wcnt == tri_words - CW'(1));
    assign eng_vend  = (vcnt == vsize - VSW'(1));
    assign eng_data  = in_data;
    assign in_ready  = !restart && eng_ready[tgt];
    assign fire      = in_valid && in_ready;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_route
        assign eng_valid[e] = in_valid && !restart && (tgt == EW'(e));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tgt       <= '0;
            wcnt      <= '0;
            vcnt      <= '0;
            first_tri <= 1'b1;
        end else if (fire) begin
            if (eng_tend) begin
                wcnt      <= '0;
                vcnt      <= '0;
                first_tri <= 1'b0;
                tgt       <= (tgt == EW'(NUM_ENG - 1)) ? '0 : tgt + EW'(1);
            end else begin
                wcnt <= wcnt + CW'(1);
                vcnt <= eng_vend ? '0 : vcnt + VSW'(1);
            end
        end
    end
endmodule

// File: rtl/out_merger.sv
module out_merger
    import tri_dispatch_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               host_valid,
    input  logic [DW-1:0]      host_data,
    input  logic               host_last,
    output logic               host_ready,
    input  logic [NUM_ENG-1:0] res_valid,
    input  logic [DW-1:0]      res_data [NUM_ENG],
    input  logic [NUM_ENG-1:0] res_last,
    output logic [NUM_ENG-1:0] res_ready,
    output logic               out_valid,
    output logic [DW-1:0]      out_data,
    output logic               out_last,
    output logic [1:0]         out_src,
    input  logic               out_ready
);
    logic busy;
    src_e bsrc;
    logic expect_eng;
    src_e sel;
    logic sel_is_eng;
    logic sel_idx;
    logic fire;

    always_comb begin
        if (busy)                  sel = bsrc;
        else if (host_valid)       sel = SRC_HOST;
        else if (res_valid[expect_eng]) sel = expect_eng ? SRC_ENG1 : SRC_ENG0;
        else                       sel = SRC_NONE;
    end

    assign sel_is_eng = (sel == SRC_ENG0) || (sel == SRC_ENG1);
    assign sel_idx    = (sel == SRC_ENG1);

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        if (sel == SRC_HOST) begin
            out_valid = host_valid;
            out_data  = host_data;
            out_last  = host_last;
        end else if (sel_is_eng) begin
            out_valid = res_valid[sel_idx];
            out_data  = res_data[sel_idx];
            out_last  = res_last[sel_idx];
        end
    end

    assign out_src    = sel;
    assign host_ready = out_ready && (sel == SRC_HOST);
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_rdy
        assign res_ready[e] = out_ready && sel_is_eng && (sel_idx == 1'(e));
    end

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            bsrc       <= SRC_NONE;
            expect_eng <= 1'b0;
        end else begin
            if (fire) begin
                busy <= !out_last;
                bsrc <= sel;
                if (out_last && sel_is_eng) expect_eng <= !expect_eng;
            end
            if (restart) expect_eng <= 1'b0;
        end
    end
endmodule

// File: rtl/tri_dispatch.sv
module tri_dispatch
    import tri_dispatch_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int VSIZE_W      = 4,
    parameter int NV_W         = 2,
    parameter int DEF_VSIZE    = 8,
    parameter int DEF_FIRST_NV = 3,
    parameter int DEF_NEXT_NV  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [VSIZE_W-1:0] cfg_vsize,
    input  logic [NV_W-1:0]    cfg_first_nv,
    input  logic [NV_W-1:0]    cfg_next_nv,
    input  logic               vin_valid,
    input  logic [DATA_W-1:0]  vin_data,
    output logic               vin_ready,
    output logic               eng0_valid,
    output logic [DATA_W-1:0]  eng0_data,
    output logic               eng0_vend,
    output logic               eng0_tend,
    input  logic               eng0_ready,
    output logic               eng1_valid,
    output logic [DATA_W-1:0]  eng1_data,
    output logic               eng1_vend,
    output logic               eng1_tend,
    input  logic               eng1_ready,
    input  logic               res0_valid,
    input  logic [DATA_W-1:0]  res0_data,
    input  logic               res0_last,
    output logic               res0_ready,
    input  logic               res1_valid,
    input  logic [DATA_W-1:0]  res1_data,
    input  logic               res1_last,
    output logic               res1_ready,
    input  logic               host_valid,
    input  logic [DATA_W-1:0]  host_data,
    input  logic               host_last,
    output logic               host_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_last,
    output logic [1:0]         out_src,
    input  logic               out_ready
);
    localparam int CW = VSIZE_W + NV_W;

    logic [VSIZE_W-1:0] vsize_q;
    logic [CW-1:0]      first_words_q;
    logic [CW-1:0]      next_words_q;
    logic [NUM_ENG-1:0] ev, er;
    logic [DATA_W-1:0]  ed;
    logic               evend, etend;
    logic [NUM_ENG-1:0] rv, rl, rr;
    logic [DATA_W-1:0]  rd [NUM_ENG];

    tri_cfg #(
        .VSW(VSIZE_W), .NVW(NV_W), .DEF_VSIZE(DEF_VSIZE),
        .DEF_FIRST_NV(DEF_FIRST_NV), .DEF_NEXT_NV(DEF_NEXT_NV)
    ) cfg_i (
        .clk(clk), .rst(rst), .load(cfg_load),
        .vsize_in(cfg_vsize), .first_nv_in(cfg_first_nv), .next_nv_in(cfg_next_nv),
        .vsize_o(vsize_q), .first_words_o(first_words_q), .next_words_o(next_words_q)
    );

    vtx_splitter #(.DW(DATA_W), .VSW(VSIZE_W), .CW(CW)) split_i (
        .clk(clk), .rst(rst), .restart(cfg_load),
        .vsize(vsize_q), .first_words(first_words_q), .next_words(next_words_q),
        .in_valid(vin_valid), .in_data(vin_data), .in_ready(vin_ready),
        .eng_valid(ev), .eng_data(ed), .eng_vend(evend), .eng_tend(etend),
        .eng_ready(er)
    );

    assign er         = {eng1_ready, eng0_ready};
    assign eng0_valid = ev[0];
    assign eng1_valid = ev[1];
    assign eng0_data  = ed;
    assign eng1_data  = ed;
    assign eng0_vend  = evend;
    assign eng1_vend  = evend;
    assign eng0_tend  = etend;
    assign eng1_tend  = etend;

    assign rv    = {res1_valid, res0_valid};
    assign rl    = {res1_last, res0_last};
    assign rd[0] = res0_data;
    assign rd[1] = res1_data;
    assign res0_ready = rr[0];
    assign res1_ready = rr[1];

    out_merger #(.DW(DATA_W)) merge_i (
        .clk(clk), .rst(rst), .restart(cfg_load),
        .host_valid(host_valid), .host_data(host_data), .host_last(host_last),
        .host_ready(host_ready),
        .res_valid(rv), .res_data(rd), .res_last(rl), .res_ready(rr),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_src(out_src), .out_ready(out_ready)
    );
endmodule

// File: rtl/tri_dispatch_chk.sv
module tri_dispatch_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_load,
    input logic       eng0_valid,
    input logic       eng0_ready,
    input logic       eng0_vend,
    input logic       eng0_tend,
    input logic       eng1_valid,
    input logic       eng1_ready,
    input logic       eng1_tend,
    input logic       host_ready,
    input logic       res0_ready,
    input logic       res1_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic [1:0] out_src
);
    a_r4_one_engine: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng0_valid, eng1_valid}));

    a_r4_swap_from0: assert property (@(posedge clk) disable iff (rst)
        (eng0_valid && eng0_ready && eng0_tend && !cfg_load) |=> !eng0_valid);

    a_r4_swap_from1: assert property (@(posedge clk) disable iff (rst)
        (eng1_valid && eng1_ready && eng1_tend && !cfg_load) |=> !eng1_valid);

    a_r6_load_restart: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !eng1_valid);

    a_r2_vend_at_tend: assert property (@(posedge clk) disable iff (rst)
        (eng0_valid && eng0_tend) |-> eng0_vend);

    a_r8_hold_source: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_src == $past(out_src)));

    a_r10_source_named: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_src != 2'd0));

    a_r11_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({host_ready, res0_ready, res1_ready}));
endmodule

bind tri_dispatch tri_dispatch_chk chk_i (.*);

// File: tb/tri_dispatch_tb_top.sv
module tri_dispatch_tb_top;

    typedef struct {
        logic [31:0] d;
        logic        l;
    } wl_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [3:0]  cfg_vsize = '0;
    logic [1:0]  cfg_first_nv = '0;
    logic [1:0]  cfg_next_nv = '0;
    logic        vin_valid = 1'b0;
    logic [31:0] vin_data = '0;
    logic        vin_ready;
    logic        eng0_valid, eng0_vend, eng0_tend;
    logic [31:0] eng0_data;
    logic        eng0_ready = 1'b0;
    logic        eng1_valid, eng1_vend, eng1_tend;
    logic [31:0] eng1_data;
    logic        eng1_ready = 1'b0;
    logic        res0_valid = 1'b0, res0_last = 1'b0;
    logic [31:0] res0_data = '0;
    logic        res0_ready;
    logic        res1_valid = 1'b0, res1_last = 1'b0;
    logic [31:0] res1_data = '0;
    logic        res1_ready;
    logic        host_valid = 1'b0, host_last = 1'b0;
    logic [31:0] host_data = '0;
    logic        host_ready;
    logic        out_valid, out_last;
    logic [31:0] out_data;
    logic [1:0]  out_src;
    logic        out_ready = 1'b0;

    always #5 clk = ~clk;

    tri_dispatch dut_i (.*);

    int total = 0;
    int fails = 0;

    wl_t eq0[$];
    wl_t eq1[$];
    wl_t hq[$];
    logic [31:0] gold[$];
    int vin_ptr = 0;
    int vin_lim = 0;
    int host_seq = 0;
    bit ld_req = 0;
    int p_in = 70, p_er = 70, p_res = 70, p_host = 50, p_or = 70;

    int m_vs = 8, m_fn = 3, m_nn = 3;
    int m_tgt = 0, m_wc = 0, m_vc = 0;
    bit m_first = 1;
    bit m_busy = 0;
    int m_bsrc = 0;
    int m_exp = 0;

    function automatic bit rnd(input int p);
        return ($urandom_range(99) < p);
    endfunction

    function automatic int nzb(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive();
        vin_valid = (vin_ptr < vin_lim) && rnd(p_in);
        vin_data  = 32'hC0DE_0000 + 32'(vin_ptr);
        eng0_ready = rnd(p_er);
        eng1_ready = rnd(p_er);
        res0_valid = (eq0.size() > 0) && rnd(p_res);
        res0_data  = (eq0.size() > 0) ? eq0[0].d : '0;
        res0_last  = (eq0.size() > 0) ? eq0[0].l : 1'b0;
        res1_valid = (eq1.size() > 0) && rnd(p_res);
        res1_data  = (eq1.size() > 0) ? eq1[0].d : '0;
        res1_last  = (eq1.size() > 0) ? eq1[0].l : 1'b0;
        host_valid = (hq.size() > 0) && rnd(p_host);
        host_data  = (hq.size() > 0) ? hq[0].d : '0;
        host_last  = (hq.size() > 0) ? hq[0].l : 1'b0;
        out_ready  = rnd(p_or);
        cfg_load   = ld_req;
        ld_req     = 0;
    endtask

    task automatic step_check();
        int tw, msel;
        bit ld, er, mv, ml, rexp;
        logic [31:0] md;
        wl_t w;
        ld = cfg_load;
        tw = (m_first ? m_fn : m_nn) * m_vs;
        er = !ld && ((m_tgt == 0) ? eng0_ready : eng1_ready);
        chk("R5 vin_ready", 32'(vin_ready), 32'(er));
        chk(ld ? "R6 eng0_valid" : "R4 eng0_valid", 32'(eng0_valid), 32'(vin_valid && !ld && m_tgt == 0));
        chk(ld ? "R6 eng1_valid" : "R4 eng1_valid", 32'(eng1_valid), 32'(vin_valid && !ld && m_tgt == 1));
        if (vin_valid && !ld) begin
            chk("R5 eng_data", (m_tgt == 0) ? eng0_data : eng1_data, vin_data);
            chk("R2 vend", 32'((m_tgt == 0) ? eng0_vend : eng1_vend), 32'(m_vc == m_vs - 1));
            chk("R3 tend", 32'((m_tgt == 0) ? eng0_tend : eng1_tend), 32'(m_wc == tw - 1));
        end

        rexp = (m_exp == 1) ? res1_valid : res0_valid;
        if (m_busy) msel = m_bsrc;
        else if (host_valid) msel = 1;
        else if (rexp) msel = 2 + m_exp;
        else msel = 0;
        case (msel)
            1: begin mv = host_valid; md = host_data; ml = host_last; end
            2: begin mv = res0_valid; md = res0_data; ml = res0_last; end
            3: begin mv = res1_valid; md = res1_data; ml = res1_last; end
            default: begin mv = 0; md = '0; ml = 0; end
        endcase
        chk((!m_busy && host_valid && rexp) ? "R9 out_src" : "R10 out_src", 32'(out_src), 32'(msel));
        chk("R11 out_valid", 32'(out_valid), 32'(mv));
        if (mv) begin
            chk("R11 out_data", out_data, md);
            chk("R8 out_last", 32'(out_last), 32'(ml));
        end
        chk("R11 host_ready", 32'(host_ready), 32'(msel == 1 && out_ready));
        chk("R7 res0_ready", 32'(res0_ready), 32'(msel == 2 && out_ready));
        chk("R7 res1_ready", 32'(res1_ready), 32'(msel == 3 && out_ready));

        if (out_valid && out_ready && out_src >= 2'd2) begin
            if (gold.size() == 0) chk("R7 order empty", out_data, 32'hFFFF_FFFF);
            else chk("R7 order", out_data, gold.pop_front());
        end
        if (host_valid && host_ready) void'(hq.pop_front());
        if (res0_valid && res0_ready) void'(eq0.pop_front());
        if (res1_valid && res1_ready) void'(eq1.pop_front());
        if (vin_valid && vin_ready) begin
            gold.push_back(vin_data);
            vin_ptr++;
            w.d = vin_data;
            if (eng0_valid) begin w.l = eng0_tend; eq0.push_back(w); end
            else begin w.l = eng1_tend; eq1.push_back(w); end
        end

        if (mv && out_ready) begin
            m_busy = !ml;
            m_bsrc = msel;
            if (ml && msel >= 2) m_exp = 1 - m_exp;
        end
        if (!ld && vin_valid && er) begin
            if (m_wc == tw - 1) begin
                m_wc = 0; m_vc = 0; m_first = 0; m_tgt = 1 - m_tgt;
            end else begin
                m_wc++;
                m_vc = (m_vc == m_vs - 1) ? 0 : m_vc + 1;
            end
        end
        if (ld) begin
            m_vs = nzb(int'(cfg_vsize));
            m_fn = nzb(int'(cfg_first_nv));
            m_nn = nzb(int'(cfg_next_nv));
            m_tgt = 0; m_wc = 0; m_vc = 0; m_first = 1; m_exp = 0;
        end
    endtask

    task automatic cycle();
        drive();
        @(negedge clk);
        step_check();
        @(posedge clk);
        #1;
    endtask

    task automatic add_host(input int bursts);
        wl_t w;
        for (int b = 0; b < bursts; b++) begin
            for (int k = 0; k <= b % 3; k++) begin
                w.d = 32'h4000_0000 + 32'(host_seq);
                w.l = (k == b % 3);
                host_seq++;
                hq.push_back(w);
            end
        end
    endtask

    task automatic drain();
        int n = 0;
        while (n < 20000 && !(vin_ptr == vin_lim && eq0.size() == 0 && eq1.size() == 0
                              && hq.size() == 0 && !m_busy && gold.size() == 0)) begin
            cycle();
            n++;
        end
        chk("R7 drained", 32'(gold.size()), 32'd0);
    endtask

    task automatic do_load(input int vs, input int fnv, input int nnv);
        cfg_vsize = 4'(vs);
        cfg_first_nv = 2'(fnv);
        cfg_next_nv = 2'(nnv);
        ld_req = 1;
        cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 eng0_valid", 32'(eng0_valid), 32'd0);
        chk("R1 eng1_valid", 32'(eng1_valid), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_src", 32'(out_src), 32'd0);
        @(posedge clk);
        #1;
        vin_valid = 1'b1; eng0_ready = 1'b1; eng1_ready = 1'b1;
        #1;
        chk("R1 first word to engine 0", 32'({eng1_valid, eng0_valid}), 32'd1);
        vin_valid = 1'b0;
        @(posedge clk);
        #1;

        // separate triangles of 8-word vertices, odd count
        vin_lim += 24 * 5;
        add_host(4);
        drain();
        // strip-like: 10 words per vertex, 3 then 1 vertex
        do_load(10, 3, 1);
        vin_lim += 30 + 10 * 5;
        add_host(3);
        drain();
        // zero fields count as one
        do_load(0, 0, 2);
        vin_lim += 1 + 2 * 8;
        add_host(2);
        drain();
        // host and engine waiting together at a boundary
        do_load(4, 3, 3);
        p_or = 0; p_in = 100; p_er = 100; p_res = 100; p_host = 100;
        vin_lim += 12 * 4;
        add_host(3);
        repeat (80) cycle();
        p_or = 100;
        drain();
        // heavy backpressure, separate triangles
        do_load(3, 3, 3);
        p_in = 50; p_er = 30; p_res = 40; p_host = 30; p_or = 40;
        vin_lim += 9 * 7;
        add_host(5);
        drain();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", vin_ptr, vin_lim);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule